// File: doc/BRIEF.md
# Remote DMA Buffer Port

This block gives a host bus byte-wide or word-wide streaming access to a network controller's packet buffer. The host first loads a 16-bit buffer pointer and a 16-bit transfer count, one byte at a time, through small register selects. It then reads or writes a single data select over and over. Each data access touches the buffer at the pointer, moves the pointer forward and takes the same amount off the count. A configuration bit chooses between moving one byte and moving one 16-bit little-endian word per access.

The buffer does not cover the whole 16-bit address space. Only two regions decode: a small low region at address 0 (`LOW_BYTES`, 32 by default) and a packet region of `PKT_BYTES` bytes that starts at `PKT_BASE` (16384). The full-size controller sets `PKT_BYTES` to 32768, which gives the window 16384 to 49151. The default build uses 4096 bytes so that the storage stays small. An access outside these regions cannot disturb the buffer. Reads there return all ones and writes there are dropped. A data write that arrives when the count is already zero is refused, so the host cannot run past the end of a transfer. The block raises a one-cycle flag when an access brings the count to zero.

Top module: `rdma_buf_port`

## Requirements
- R1: After a synchronous reset, the pointer, the count and the mode bit are all zero. `rdata_o`, `rvalid_o` and `done_o` are also zero.
- R2: A write with `sel_i` = 1, 2, 3 or 4 loads `wdata_i[7:0]` into the pointer low byte, the pointer high byte, the count low byte or the count high byte. A write with `sel_i` = 5 loads the mode bit from `wdata_i[0]` (1 selects word mode). Reading one of these selects returns the byte zero-extended to 16 bits. Reading select 5 returns the mode bit in bit 0.
- R3: Byte addresses below `LOW_BYTES` (32), and byte addresses from `PKT_BASE` (16384) up to but not including `PKT_BASE+PKT_BYTES`, hold data. A byte-mode data write followed by a data read at the same address returns `{8'h00, byte}`.
- R4: A data read outside the window returns 16'h00FF in byte mode and 16'hFFFF in word mode.
- R5: A data write outside the window leaves every buffer location unchanged. The pointer and the count still step.
- R6: In word mode, a data write puts `wdata_i[7:0]` at the even address and `wdata_i[15:8]` at the next address. A data read returns `{byte at even+1, byte at even}`.
- R7: In word mode, the buffer is accessed at the pointer with bit 0 cleared. The pointer itself still advances by 2 from its unaligned value.
- R8: Every data read, and every data write made while the count is nonzero, adds 1 (byte mode) or 2 (word mode) to the pointer and subtracts the same amount from the count. Both values wrap at 16 bits.
- R9: A data write made while the count is zero changes neither the buffer, nor the pointer, nor the count.
- R10: Data reads are not blocked at count zero. A byte read at count 0 leaves the count at 16'hFFFF.
- R11: `done_o` is high for exactly the one cycle after the clock edge at which a data access steps the count from nonzero to zero. It stays low when a step wraps the count to another value, for example a word access at count 1.
- R12: Read data appears on `rdata_o`, with `rvalid_o` high for one cycle, at the second rising edge after the edge that sampled `rd_i`. When `wr_i` and `rd_i` are both high, only the write is performed and no read result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Select: 0 data, 1 pointer low, 2 pointer high, 3 count low, 4 count high, 5 mode |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| wdata_i | input | 16 | Write data (bits 7:0 only, except in word-mode data writes) |
| rdata_o | output | 16 | Registered read result, held between reads |
| rvalid_o | output | 1 | Read result valid pulse |
| done_o | output | 1 | Count reached zero pulse |

## Verification
A register or data write changes the pointer, the count and the buffer at the rising edge that samples it, and `done_o` goes high in the cycle that follows that edge. A read result takes two edges: the buffer and the register byte are captured at the sampling edge, and `rdata_o` and `rvalid_o` are loaded at the next edge. Each bench task drives its inputs on a falling edge and samples the outputs on a falling edge. `done_o` is sampled on the first falling edge after the access, and read data on the second. The R12 check also confirms that `rvalid_o` is still low at the first falling edge.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int RDMA_AW = 16;

  typedef enum logic [2:0] {
    SEL_DATA    = 3'd0,
    SEL_PTR_LO  = 3'd1,
    SEL_PTR_HI  = 3'd2,
    SEL_CNT_LO  = 3'd3,
    SEL_CNT_HI  = 3'd4,
    SEL_MODE    = 3'd5
  } rdma_sel_e;
endpackage

// File: rtl/rdma_ptr_regs.sv
module rdma_ptr_regs
  import rdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_ptr_lo,
  input  logic               ld_ptr_hi,
  input  logic               ld_cnt_lo,
  input  logic               ld_cnt_hi,
  input  logic               ld_mode,
  input  logic [7:0]         ld_byte,
  input  logic               step,
  output logic [RDMA_AW-1:0] ptr_q,
  output logic [RDMA_AW-1:0] cnt_q,
  output logic               word_q,
  output logic               done_q
);
  logic [RDMA_AW-1:0] inc;
  logic [RDMA_AW-1:0] cnt_nx;

  assign inc    = word_q ? RDMA_AW'(2) : RDMA_AW'(1);
  assign cnt_nx = cnt_q - inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      word_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld_ptr_lo) ptr_q[7:0]  <= ld_byte;
      if (ld_ptr_hi) ptr_q[15:8] <= ld_byte;
      if (ld_cnt_lo) cnt_q[7:0]  <= ld_byte;
      if (ld_cnt_hi) cnt_q[15:8] <= ld_byte;
      if (ld_mode)   word_q      <= ld_byte[0];
      if (step) begin
        ptr_q  <= ptr_q + inc;
        cnt_q  <= cnt_nx;
        done_q <= (cnt_nx == '0);
      end
    end
  end
endmodule

// File: rtl/rdma_win_decode.sv
module rdma_win_decode
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int PKT_BASE  = 16384,
  parameter int PKT_BYTES = 4096,
  parameter int IW        = 12
) (
  input  logic [RDMA_AW-1:0] ptr,
  input  logic               word,
  output logic               in_win,
  output logic               odd,
  output logic [IW-1:0]      idx
);
  localparam logic [RDMA_AW:0] LOW_LIM = (RDMA_AW+1)'(LOW_BYTES);
  localparam logic [RDMA_AW:0] PKT_LO  = (RDMA_AW+1)'(PKT_BASE);
  localparam logic [RDMA_AW:0] PKT_HI  = (RDMA_AW+1)'(PKT_BASE + PKT_BYTES);

  logic [RDMA_AW-1:0] eff;
  logic [RDMA_AW:0]   ext;
  logic [RDMA_AW-1:0] off;
  logic               in_low;

  assign eff    = word ? {ptr[RDMA_AW-1:1], 1'b0} : ptr;
  assign ext    = {1'b0, eff};
  assign in_low = ext < LOW_LIM;
  assign in_win = in_low || ((ext >= PKT_LO) && (ext < PKT_HI));
  assign off    = eff - RDMA_AW'(PKT_BASE);
  assign odd    = eff[0];
  assign idx    = in_low ? IW'(eff[RDMA_AW-1:1])
                         : IW'(LOW_BYTES / 2) + IW'(off[RDMA_AW-1:1]);
endmodule

// File: rtl/rdma_lane_ram.sv
module rdma_lane_ram #(
  parameter int DEPTH = 2064,
  parameter int IW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wd,
  output logic [7:0]    rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) rq <= mem[idx];
  end
endmodule

// File: rtl/rdma_buf_port.sv
module rdma_buf_port
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int PKT_BASE  = 16384,
  parameter int PKT_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  sel_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        rvalid_o,
  output logic        done_o
);
  localparam int DEPTH = (LOW_BYTES + PKT_BYTES) / 2;
  localparam int IW    = $clog2(DEPTH);

  logic [RDMA_AW-1:0] ptr_q;
  logic [RDMA_AW-1:0] cnt_q;
  logic               word_q;
  logic               acc_rd;
  logic               data_wr;
  logic               data_rd;
  logic               in_win;
  logic               odd;
  logic [IW-1:0]      idx;
  logic [7:0]         lane_q [2];
  logic [7:0]         reg_byte;

  assign acc_rd  = rd_i & ~wr_i;
  assign data_wr = wr_i & (sel_i == SEL_DATA) & (cnt_q != '0);
  assign data_rd = acc_rd & (sel_i == SEL_DATA);

  rdma_ptr_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .ld_ptr_lo (wr_i & (sel_i == SEL_PTR_LO)),
    .ld_ptr_hi (wr_i & (sel_i == SEL_PTR_HI)),
    .ld_cnt_lo (wr_i & (sel_i == SEL_CNT_LO)),
    .ld_cnt_hi (wr_i & (sel_i == SEL_CNT_HI)),
    .ld_mode   (wr_i & (sel_i == SEL_MODE)),
    .ld_byte   (wdata_i[7:0]),
    .step      (data_wr | data_rd),
    .ptr_q     (ptr_q),
    .cnt_q     (cnt_q),
    .word_q    (word_q),
    .done_q    (done_o)
  );

  rdma_win_decode #(
    .LOW_BYTES (LOW_BYTES),
    .PKT_BASE  (PKT_BASE),
    .PKT_BYTES (PKT_BYTES),
    .IW        (IW)
  ) u_dec (
    .ptr    (ptr_q),
    .word   (word_q),
    .in_win (in_win),
    .odd    (odd),
    .idx    (idx)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic       we;
    logic [7:0] wd;
    assign we = data_wr & in_win & (word_q | (odd == 1'(l)));
    assign wd = ((l == 0) || !word_q) ? wdata_i[7:0] : wdata_i[15:8];
    rdma_lane_ram #(.DEPTH(DEPTH), .IW(IW)) u_ram (
      .clk (clk),
      .we  (we),
      .re  (data_rd),
      .idx (idx),
      .wd  (wd),
      .rq  (lane_q[l])
    );
  end

  always_comb begin
    case (sel_i)
      SEL_PTR_LO: reg_byte = ptr_q[7:0];
      SEL_PTR_HI: reg_byte = ptr_q[15:8];
      SEL_CNT_LO: reg_byte = cnt_q[7:0];
      SEL_CNT_HI: reg_byte = cnt_q[15:8];
      SEL_MODE:   reg_byte = {7'd0, word_q};
      default:    reg_byte = 8'd0;
    endcase
  end

  logic       s1_valid, s1_data, s1_word, s1_odd, s1_win;
  logic [7:0] s1_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_data  <= 1'b0;
      s1_word  <= 1'b0;
      s1_odd   <= 1'b0;
      s1_win   <= 1'b0;
      s1_reg   <= 8'd0;
      rvalid_o <= 1'b0;
      rdata_o  <= 16'd0;
    end else begin
      s1_valid <= acc_rd;
      s1_data  <= sel_i == SEL_DATA;
      s1_word  <= word_q;
      s1_odd   <= odd;
      s1_win   <= in_win;
      s1_reg   <= reg_byte;
      rvalid_o <= s1_valid;
      if (s1_valid) begin
        if (!s1_data)
          rdata_o <= {8'd0, s1_reg};
        else if (s1_word)
          rdata_o <= s1_win ? {lane_q[1], lane_q[0]} : 16'hFFFF;
        else
          rdata_o <= s1_win ? {8'd0, (s1_odd ? lane_q[1] : lane_q[0])} : 16'h00FF;
      end
    end
  end
endmodule

// File: rtl/rdma_buf_port_chk.sv
module rdma_buf_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  sel_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [15:0] ptr_q,
  input logic [15:0] cnt_q,
  input logic        word_q,
  input logic        done_o,
  input logic        rvalid_o
);
  logic stepping;
  assign stepping = (sel_i == 3'd0) && ((rd_i && !wr_i) || (wr_i && cnt_q != 16'd0));

  AST_ZERO_CNT_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == 3'd0 && cnt_q == 16'd0) |=> ($stable(ptr_q) && $stable(cnt_q))); // R9

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    (stepping && !word_q) |=>
      (ptr_q == $past(ptr_q) + 16'd1 && cnt_q == $past(cnt_q) - 16'd1)); // R8

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (stepping && word_q) |=>
      (ptr_q == $past(ptr_q) + 16'd2 && cnt_q == $past(cnt_q) - 16'd2)); // R8

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cnt_q == 16'd0); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11

  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(rd_i && !wr_i, 2)); // R12
endmodule

bind rdma_buf_port rdma_buf_port_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .ptr_q    (ptr_q),
  .cnt_q    (cnt_q),
  .word_q   (word_q),
  .done_o   (done_o),
  .rvalid_o (rvalid_o)
);

// File: tb/rdma_buf_port_bench.sv
module rdma_buf_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel_i = 3'd0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic        rvalid_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic last_done;
  logic rv_mid;

  always #4 clk = ~clk;

  rdma_buf_port u_rdma_buf_port (
    .clk(clk), .rst(rst), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        rd;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd2, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd3, 1'b0, 16'h0010, 16'h0000, 4'd0},
    '{3'd4, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd0, 1'b0, 16'h00A5, 16'h0000, 4'd0},
    '{3'd0, 1'b0, 16'h005A, 16'h0000, 4'd0},
    '{3'd1, 1'b1, 16'h0000, 16'h0002, 4'd8},  // R8 pointer stepped twice
    '{3'd3, 1'b1, 16'h0000, 16'h000E, 4'd8},  // R8 count down by two
    '{3'd1, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'h00A5, 4'd3},  // R3 low region byte 0
    '{3'd0, 1'b1, 16'h0000, 16'h005A, 4'd3},  // R3 low region byte 1
    '{3'd2, 1'b0, 16'h0040, 16'h0000, 4'd0},
    '{3'd1, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd0, 1'b0, 16'h003C, 16'h0000, 4'd0},
    '{3'd1, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'h003C, 4'd3},  // R3 packet region base
    '{3'd2, 1'b0, 16'h003F, 16'h0000, 4'd0},
    '{3'd1, 1'b0, 16'h00FF, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'h00FF, 4'd4},  // R4 just below window
    '{3'd0, 1'b1, 16'h0000, 16'h003C, 4'd3},  // R3 crossing into window
    '{3'd5, 1'b0, 16'h0001, 16'h0000, 4'd0},
    '{3'd5, 1'b1, 16'h0000, 16'h0001, 4'd2},  // R2 mode readback
    '{3'd1, 1'b0, 16'h0010, 16'h0000, 4'd0},
    '{3'd0, 1'b0, 16'hBEEF, 16'h0000, 4'd0},
    '{3'd3, 1'b1, 16'h0000, 16'h0006, 4'd8},  // R8 word step of count
    '{3'd2, 1'b1, 16'h0000, 16'h0040, 4'd2},  // R2 pointer high readback
    '{3'd5, 1'b0, 16'h0000, 16'h0000, 4'd0},
    '{3'd1, 1'b0, 16'h0010, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'h00EF, 4'd6},  // R6 low byte at even
    '{3'd0, 1'b1, 16'h0000, 16'h00BE, 4'd6},  // R6 high byte at odd
    '{3'd5, 1'b0, 16'h0001, 16'h0000, 4'd0},
    '{3'd1, 1'b0, 16'h0011, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'hBEEF, 4'd7},  // R7 odd pointer aligned down
    '{3'd1, 1'b1, 16'h0000, 16'h0013, 4'd7},  // R7 pointer kept unaligned
    '{3'd2, 1'b0, 16'h0080, 16'h0000, 4'd0},
    '{3'd0, 1'b1, 16'h0000, 16'hFFFF, 4'd4},  // R4 word read outside
    '{3'd5, 1'b0, 16'h0000, 16'h0000, 4'd0}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    sel_i = s; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk);
    wr_i = 1'b0;
    last_done = done_o;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] q);
    @(negedge clk);
    sel_i = s; rd_i = 1'b1; wr_i = 1'b0;
    @(negedge clk);
    rd_i = 1'b0;
    last_done = done_o;
    rv_mid = rvalid_o;
    @(negedge clk);
    q = rvalid_o ? rdata_o : 16'hDEAD;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(3'd2, {8'd0, p[15:8]});
    wr(3'd1, {8'd0, p[7:0]});
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(3'd4, {8'd0, c[15:8]});
    wr(3'd3, {8'd0, c[7:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check(1, rdata_o, 16'h0000);
    check(1, {15'd0, rvalid_o}, 16'h0000);
    check(1, {15'd0, done_o}, 16'h0000);
    rd(3'd1, q); check(1, q, 16'h0000);
    rd(3'd3, q); check(1, q, 16'h0000);
    rd(3'd5, q); check(1, q, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].sel, q);
        check(int'(VEC[i].req), q, VEC[i].exp);
      end else begin
        wr(VEC[i].sel, VEC[i].data);
      end
    end

    // R11 done pulse, R9 write at zero count ignored
    set_ptr(16'h4020); set_cnt(16'h0002);
    wr(3'd0, 16'h0011); check(11, {15'd0, last_done}, 16'h0000);
    wr(3'd0, 16'h0077); check(11, {15'd0, last_done}, 16'h0001);
    wr(3'd1, 16'h0021);
    wr(3'd0, 16'h0022); check(11, {15'd0, last_done}, 16'h0000);
    rd(3'd1, q); check(9, q, 16'h0021);
    rd(3'd3, q); check(9, q, 16'h0000);
    rd(3'd0, q); check(9, q, 16'h0077);
    // R10 read at zero count wraps count
    rd(3'd3, q); check(10, q, 16'h00FF);
    rd(3'd4, q); check(10, q, 16'h00FF);

    // R5 writes outside the window are discarded
    set_ptr(16'h0020);
    wr(3'd0, 16'h0099);
    rd(3'd1, q); check(5, q, 16'h0021);
    set_ptr(16'h5000);
    wr(3'd0, 16'h0099);
    set_ptr(16'h4000);
    rd(3'd0, q); check(5, q, 16'h003C);
    set_ptr(16'h0000);
    rd(3'd0, q); check(5, q, 16'h00A5);
    set_ptr(16'h0020);
    rd(3'd0, q); check(4, q, 16'h00FF);  // R4 just past low region

    // R8 pointer wraps at 16 bits
    set_ptr(16'hFFFF);
    rd(3'd0, q);
    rd(3'd2, q); check(8, q, 16'h0000);
    rd(3'd1, q); check(8, q, 16'h0000);

    // R11 word step from count 1 wraps without done
    wr(3'd5, 16'h0001);
    set_cnt(16'h0001); set_ptr(16'h4010);
    rd(3'd0, q);
    check(11, {15'd0, last_done}, 16'h0000);
    check(6, q, 16'hBEEF);  // R6 word read
    rd(3'd3, q); check(11, q, 16'h00FF);

    // R12 latency and write priority
    rd(3'd1, q);
    check(12, {15'd0, rv_mid}, 16'h0000);
    check(12, q, 16'h0012);
    @(negedge clk);
    sel_i = 3'd1; wdata_i = 16'h0055; wr_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    @(negedge clk);
    check(12, {15'd0, rvalid_o}, 16'h0000);
    rd(3'd1, q); check(12, q, 16'h0055);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule